// File: doc/BRIEF.md
# Serial Audio Receiver with Automatic Mute

This block takes stereo audio that arrives as two serial data lines, one per channel, sharing a bit clock and a word clock. Every bit clock rising edge shifts one bit, most significant first, into a per-channel shift register. A falling word clock edge copies the newest bits of each register into a parallel sample register. The word length is 24 bits or 20 bits. A 20-bit word is sign-extended to the 24-bit output. The bit clock may stop between bits or arrive in bursts, because only its edges matter.

The serial clocks are sampled by the system clock through two-stage synchronizers, and all edges are found in the system domain. Three conditions drive the mute flag:
- an external mute request;
- a silence detector that fires when a channel captures the same word many times in a row;
- a clock watchdog that fires when the word clock stops toggling.

Downstream logic reads the samples when the strobe pulses and silences its output while the mute flag is high.

Top module: `audio_rx_mute`

## Requirements
- R1: Each bit clock rising edge shifts the current data line value into that channel's register, with the MSB arriving first. A captured sample holds the most recent bits, with the last bit shifted in landing in bit 0.
- R2: A falling word clock edge captures both channels. `sampleValid` pulses high for exactly one system clock, in the same cycle that `sampleL` and `sampleR` change. That cycle follows the third rising system clock edge after the word clock input falls. At all other times the samples hold their value.
- R3: When `wordSel24` is 1, a capture takes the last 24 bits shifted in.
- R4: When `wordSel24` is 0, a capture takes the last 20 bits into bits 19:0 and copies bit 19 into bits 23:20.
- R5: Gaps of any length between bit clock pulses do not change the captured word.
- R6: Each channel counts its consecutive captures that equal that channel's previous sample. The first capture after reset is compared with zero. The silence mute asserts with the capture that brings either channel's count to SILENT_WORDS (default 8192).
- R7: A capture whose word differs from the channel's previous sample resets that channel's count. The silence mute drops on the first capture after which neither channel's count is at SILENT_WORDS.
- R8: The clock-loss mute asserts when LOSS_CYCLES (default 4096) system clocks pass with no word clock edge, counted in the synchronized domain. It clears one cycle after the next synchronized edge is seen.
- R9: `muteOut` is the OR of `muteIn`, the silence mute and the clock-loss mute. `muteIn` reaches `muteOut` with no register delay.
- R10: While `rstN` is low, the samples are zero and `sampleValid` is low. Neither internal mute is set, so `muteOut` equals `muteIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock; data is shifted on its rising edge |
| wordClk | input | 1 | Word clock; its falling edge captures the sample |
| dataL | input | 1 | Left channel serial data, MSB first |
| dataR | input | 1 | Right channel serial data, MSB first |
| wordSel24 | input | 1 | 1 selects 24-bit words, 0 selects 20-bit words |
| muteIn | input | 1 | External mute request, active high |
| sampleL | output | 24 | Left sample, two's complement |
| sampleR | output | 24 | Right sample, two's complement |
| sampleValid | output | 1 | One-cycle strobe marking a new sample pair |
| muteOut | output | 1 | Combined mute flag |

## Verification
The assertions assume the following about the inputs:
- Each level of the bit clock and of the word clock lasts at least two system clocks, so no edge is lost in the synchronizers.
- The data lines settle before the bit clock rises.
- `wordSel24` changes only between words.

The stimulus follows these rules. It changes the word clock only together with a falling bit clock, holds each clock level for two or more system clocks, and drives every input on the falling system clock edge. A separate phase stops the word clock well beyond the loss window, and another inserts long irregular gaps between bits.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  // depth of the synchronizer chain on every serial input
  localparam int SYNC_DEPTH = 2;
  localparam int CHANNELS = 2;

  // strobes passed from control to datapath
  typedef struct packed {
    logic shift;    // bit clock rising edge seen
    logic capture;  // word clock falling edge seen
  } rx_strobe_t;
endpackage

// File: rtl/audio_rx_ctrl.sv
module audio_rx_ctrl
  import audio_rx_pkg::*;
#(
  parameter int LOSS_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       wordClk,
  output rx_strobe_t strobe,
  output logic       lossMute
);
  localparam int CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LOSS_MAX = CW'(LOSS_CYCLES);

  logic [SYNC_DEPTH-1:0] bitSync, wordSync;
  logic bitPrev, wordPrev;
  logic bitNow, wordNow, wordEdge;
  logic [CW-1:0] idleCnt, idleNext;

  assign bitNow  = bitSync[SYNC_DEPTH-1];
  assign wordNow = wordSync[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitSync  <= '0;
      wordSync <= '0;
      bitPrev  <= 1'b0;
      wordPrev <= 1'b0;
    end else begin
      bitSync  <= {bitSync[SYNC_DEPTH-2:0], bitClk};
      wordSync <= {wordSync[SYNC_DEPTH-2:0], wordClk};
      bitPrev  <= bitNow;
      wordPrev <= wordNow;
    end
  end

  always_comb begin
    strobe.shift   = bitNow & ~bitPrev;
    strobe.capture = ~wordNow & wordPrev;
    wordEdge       = wordNow ^ wordPrev;
  end

  // watchdog on the word clock, saturating at the loss limit
  always_comb begin
    if (wordEdge)                idleNext = '0;
    else if (idleCnt == LOSS_MAX) idleNext = idleCnt;
    else                         idleNext = idleCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt  <= '0;
      lossMute <= 1'b0;
    end else begin
      idleCnt  <= idleNext;
      lossMute <= (idleNext == LOSS_MAX);
    end
  end
endmodule

// File: rtl/audio_rx_datapath.sv
module audio_rx_datapath
  import audio_rx_pkg::*;
#(
  parameter int WORD_W       = 24,
  parameter int NARROW_W     = 20,
  parameter int SILENT_WORDS = 8192
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  rx_strobe_t                       strobe,
  input  logic                             wordSel24,
  input  logic [CHANNELS-1:0]              serIn,
  output logic [CHANNELS-1:0][WORD_W-1:0]  sample,
  output logic                             sampleValid,
  output logic                             silentMute
);
  localparam int SW = $clog2(SILENT_WORDS + 1);
  localparam logic [SW-1:0] SILENT_MAX = SW'(SILENT_WORDS);
  localparam int EXT_W = WORD_W - NARROW_W;

  logic [CHANNELS-1:0] runFull;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [SYNC_DEPTH-1:0] serSync;
    logic [WORD_W-1:0]     shiftReg, capWord, sampleReg;
    logic [SW-1:0]         runCnt, runNext;

    always_comb begin
      if (wordSel24) capWord = shiftReg;
      else           capWord = {{EXT_W{shiftReg[NARROW_W-1]}}, shiftReg[NARROW_W-1:0]};
      if (capWord != sampleReg)      runNext = '0;
      else if (runCnt == SILENT_MAX) runNext = runCnt;
      else                           runNext = runCnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        serSync   <= '0;
        shiftReg  <= '0;
        sampleReg <= '0;
        runCnt    <= '0;
      end else begin
        serSync <= {serSync[SYNC_DEPTH-2:0], serIn[ch]};
        if (strobe.shift)
          shiftReg <= {shiftReg[WORD_W-2:0], serSync[SYNC_DEPTH-1]};
        if (strobe.capture) begin
          sampleReg <= capWord;
          runCnt    <= runNext;
        end
      end
    end

    assign runFull[ch] = (runNext == SILENT_MAX);
    assign sample[ch]  = sampleReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleValid <= 1'b0;
      silentMute  <= 1'b0;
    end else begin
      sampleValid <= strobe.capture;
      if (strobe.capture) silentMute <= |runFull;
    end
  end
endmodule

// File: rtl/audio_rx_mute.sv
module audio_rx_mute
  import audio_rx_pkg::*;
#(
  parameter int WORD_W       = 24,
  parameter int NARROW_W     = 20,
  parameter int SILENT_WORDS = 8192,
  parameter int LOSS_CYCLES  = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              wordClk,
  input  logic              dataL,
  input  logic              dataR,
  input  logic              wordSel24,
  input  logic              muteIn,
  output logic [WORD_W-1:0] sampleL,
  output logic [WORD_W-1:0] sampleR,
  output logic              sampleValid,
  output logic              muteOut
);
  rx_strobe_t strobe;
  logic lossMute, silentMute;
  logic [CHANNELS-1:0][WORD_W-1:0] sample;

  audio_rx_ctrl #(.LOSS_CYCLES(LOSS_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk),
    .strobe(strobe), .lossMute(lossMute)
  );

  audio_rx_datapath #(
    .WORD_W(WORD_W), .NARROW_W(NARROW_W), .SILENT_WORDS(SILENT_WORDS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordSel24(wordSel24),
    .serIn({dataR, dataL}), .sample(sample),
    .sampleValid(sampleValid), .silentMute(silentMute)
  );

  assign sampleL = sample[0];
  assign sampleR = sample[1];
  assign muteOut = muteIn | silentMute | lossMute;
endmodule

// File: rtl/audio_rx_mute_checker.sv
module audio_rx_mute_checker #(
  parameter int WORD_W   = 24,
  parameter int NARROW_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordSel24,
  input logic              muteIn,
  input logic [WORD_W-1:0] sampleL,
  input logic [WORD_W-1:0] sampleR,
  input logic              sampleValid,
  input logic              muteOut,
  input logic              silentMute,
  input logic              lossMute
);
  // R2: strobe lasts a single cycle
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R2: samples move only together with the strobe
  p_sample_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(sampleL) && $stable(sampleR)));

  // R4: 20-bit captures are sign-extended
  p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !$past(wordSel24)) |->
      (sampleL[WORD_W-1:NARROW_W] == {(WORD_W-NARROW_W){sampleL[NARROW_W-1]}} &&
       sampleR[WORD_W-1:NARROW_W] == {(WORD_W-NARROW_W){sampleR[NARROW_W-1]}}));

  // R6: silence mute changes only at a capture
  p_silent_at_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(silentMute) || $fell(silentMute)) |-> sampleValid);

  // R9: external request always reaches the output
  p_ext_mute_r9: assert property (@(posedge clk) disable iff (!rstN)
    muteIn |-> muteOut);

  // R9: no mute without a source
  p_mute_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!muteIn && !silentMute && !lossMute) |-> !muteOut);

  // R10: internal mutes are clear during reset
  always_comb begin
    if (!rstN) begin
      a_reset_clear_r10: assert (!silentMute && !lossMute && !sampleValid);
    end
  end
endmodule

bind audio_rx_mute audio_rx_mute_checker #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_checker (
  .clk(clk), .rstN(rstN), .wordSel24(wordSel24), .muteIn(muteIn),
  .sampleL(sampleL), .sampleR(sampleR), .sampleValid(sampleValid),
  .muteOut(muteOut), .silentMute(silentMute), .lossMute(lossMute)
);

// File: tb/audio_rx_mute_bench.sv
`timescale 1ns/1ps
module audio_rx_mute_bench;
  localparam int SILENT = 6;
  localparam int LOSS   = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0, wordClk = 1'b0, dataL = 1'b0, dataR = 1'b0;
  logic wordSel24 = 1'b1, muteIn = 1'b0;
  logic [23:0] sampleL, sampleR;
  logic sampleValid, muteOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_rx_mute #(.SILENT_WORDS(SILENT), .LOSS_CYCLES(LOSS)) u_audio_rx_mute (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk),
    .dataL(dataL), .dataR(dataR), .wordSel24(wordSel24), .muteIn(muteIn),
    .sampleL(sampleL), .sampleR(sampleR), .sampleValid(sampleValid), .muteOut(muteOut)
  );

  // ---------------- behavioural reference ----------------
  bit bH[1:3], wH[1:3], lH[1:3], rH[1:3];
  logic [23:0] shL, shR, mL, mR;
  int runL, runR, idle;
  bit mValid, mSil, mLoss;

  function automatic logic [23:0] pick(logic [23:0] s, bit w24);
    return w24 ? s : {{4{s[19]}}, s[19:0]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 1; i <= 3; i++) begin bH[i] = 0; wH[i] = 0; lH[i] = 0; rH[i] = 0; end
      shL = '0; shR = '0; mL = '0; mR = '0;
      runL = 0; runR = 0; idle = 0;
      mValid = 0; mSil = 0; mLoss = 0;
    end else begin
      automatic bit rise = bH[2] && !bH[3];
      automatic bit fall = !wH[2] && wH[3];
      automatic bit wedge = wH[2] != wH[3];
      mValid = fall;
      if (fall) begin
        automatic logic [23:0] nl = pick(shL, wordSel24);
        automatic logic [23:0] nr = pick(shR, wordSel24);
        runL = (nl == mL) ? ((runL == SILENT) ? runL : runL + 1) : 0;
        runR = (nr == mR) ? ((runR == SILENT) ? runR : runR + 1) : 0;
        mSil = (runL == SILENT) || (runR == SILENT);
        mL = nl; mR = nr;
      end
      if (rise) begin
        shL = {shL[22:0], lH[2]};
        shR = {shR[22:0], rH[2]};
      end
      if (wedge) idle = 0;
      else if (idle < LOSS) idle++;
      mLoss = (idle == LOSS);
      for (int i = 3; i >= 2; i--) begin
        bH[i] = bH[i-1]; wH[i] = wH[i-1]; lH[i] = lH[i-1]; rH[i] = rH[i-1];
      end
      bH[1] = bitClk; wH[1] = wordClk; lH[1] = dataL; rH[1] = dataR;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(wordSel24 ? "R3" : "R4", "sampleL", 32'(sampleL), 32'(mL));
      check(wordSel24 ? "R3" : "R4", "sampleR", 32'(sampleR), 32'(mR));
      check("R2", "sampleValid", 32'(sampleValid), 32'(mValid));
      check("R9", "muteOut", 32'(muteOut), 32'(muteIn | mSil | mLoss));
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendWord(logic [23:0] l, logic [23:0] r, int nb, int half, int gap);
    wordClk = 1'b1;
    for (int i = nb - 1; i >= 0; i--) begin
      dataL = l[i]; dataR = r[i]; bitClk = 1'b0;
      repeat (half + ((i % 3 == 0) ? gap : 0)) @(negedge clk);
      bitClk = 1'b1;
      repeat (half) @(negedge clk);
    end
    bitClk = 1'b0; wordClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [23:0] ext20(logic [23:0] v);
    return {{4{v[19]}}, v[19:0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reset sampleL", 32'(sampleL), 32'h0);
    check("R10", "reset valid", 32'(sampleValid), 32'h0);
    check("R10", "reset mute", 32'(muteOut), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R3: 24-bit words, MSB first
    sendWord(24'hA5C3F1, 24'h123456, 24, 2, 0);
    check("R1", "24-bit left", 32'(sampleL), 32'hA5C3F1);
    check("R3", "24-bit right", 32'(sampleR), 32'h123456);
    sendWord(24'h7FFFFF, 24'h800000, 24, 3, 0);
    check("R3", "max left", 32'(sampleL), 32'h7FFFFF);
    check("R3", "min right", 32'(sampleR), 32'h800000);

    // R4: 20-bit words, negative and positive
    wordSel24 = 1'b0;
    sendWord(24'h0_8_1234, 24'h0_7_ABCD, 20, 2, 0);
    check("R4", "20-bit negative", 32'(sampleL), 32'(ext20(24'h081234)));
    check("R4", "20-bit positive", 32'(sampleR), 32'(ext20(24'h07ABCD)));
    wordSel24 = 1'b1;

    // R5: bursty bit clock with long gaps
    sendWord(24'h3C96E1, 24'hC0FFEE, 24, 2, 37);
    check("R5", "burst left", 32'(sampleL), 32'h3C96E1);
    check("R5", "burst right", 32'(sampleR), 32'hC0FFEE);

    // R6: left constant, right changing
    sendWord(24'h055AA0, 24'h000001, 24, 2, 0);
    for (int k = 0; k < SILENT - 1; k++) sendWord(24'h055AA0, 24'(k + 2), 24, 2, 0);
    check("R6", "one repeat short of limit", 32'(muteOut), 32'h0);
    sendWord(24'h055AA0, 24'h0000F0, 24, 2, 0);
    check("R6", "silence mute set", 32'(muteOut), 32'h1);
    // R7: differing word clears
    sendWord(24'h055AA1, 24'h0000F1, 24, 2, 0);
    check("R7", "silence mute cleared", 32'(muteOut), 32'h0);

    // R9: external mute, no delay
    muteIn = 1'b1; #1;
    check("R9", "external mute", 32'(muteOut), 32'h1);
    @(negedge clk); muteIn = 1'b0; #1;
    check("R9", "external release", 32'(muteOut), 32'h0);

    // R8: word clock stopped
    repeat (LOSS + 10) @(negedge clk);
    check("R8", "clock loss mute", 32'(muteOut), 32'h1);
    wordClk = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", "clock loss cleared", 32'(muteOut), 32'h0);
    sendWord(24'h0F0F0F, 24'hF0F0F0, 24, 2, 0);
    check("R1", "after recovery", 32'(sampleL), 32'h0F0F0F);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule